// File: doc/BRIEF.md
# Interrupt Status Register Bank

This block collects event flags for a processor-facing register space. Each bit of each status register watches one live condition input. When that condition goes from low to high or from high to low, the status bit latches high and stays high until software clears it. A per-bit mask register decides which latched bits may drive the single interrupt line. Software can also read the current sampled level of every condition without touching the latched state.

One configuration bit picks how software clears status. With the bit at 1 (the value after reset), reading a status register clears every bit in it, and the read returns the value held just before the clear. With the bit at 0, writing a 1 to a status bit clears that bit alone. Writing a 0 leaves the bit alone, and reads leave everything as it was. If a condition changes in the same cycle that software clears its bit, the new event is kept.

The register port is a plain strobe interface: address, read strobe, write strobe, write data and a registered read data bus. Read data appears on the cycle after the read strobe is accepted. The address map, with NUM_REGS=3, is: status registers at 0..2, mask registers at 3..5, live-level registers at 6..8, and the configuration register at 9 (bit 0 = clear policy). Any other address reads as zero.

Top module: `irq_stat_bank`

## Requirements
- R1: With the policy bit at 1, a read strobe to status register k (address k) returns, on rd_data one cycle later, the value held before the clear, and all bits of register k are cleared on the accepting clock edge.
- R2: With the policy bit at 0, a write to status address k clears exactly the bits written as 1 and keeps those written as 0, and reads never clear. With the policy bit at 1, writes to status addresses have no effect.
- R3: After reset the policy bit (address 9, bit 0) reads 1, every mask register reads all ones, every status bit is 0, irq_out is 0 and rd_data is 0.
- R4: A low-to-high change on live_in bit b sets status bit b mod 16 of register b/16. The bit can be read at the latest three clock cycles after the change.
- R5: A high-to-low change on a live_in bit sets its status bit in the same way as a rising change.
- R6: irq_out is high, from a registered output, when any status bit is 1 and its mask bit is 0. With all masks at 1, irq_out stays low.
- R7: When a set event and a clear, whether by read or by write-one, hit the same status bit in the same cycle, the bit ends up set.
- R8: A live_in pattern held steady across the release of reset produces no status bit.
- R9: Reading address 6+k returns the sampled live levels of register k and never clears any status bit.
- R10: The mask registers (addresses 3+k) and the policy bit read back the values written last. Addresses above 9 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_in | input | NUM_REGS*REG_W | Live condition levels; bit b maps to register b/REG_W, bit b%REG_W |
| addr | input | ADDR_W | Register address |
| rd_en | input | 1 | Read strobe, accepted on the clock edge |
| wr_en | input | 1 | Write strobe, accepted on the clock edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, valid the cycle after rd_en |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a condition edge that sets a status bit landing on the same clock edge as a software clear of that bit. Both clear forms are tested. The bench toggles a live bit one cycle before it issues either a clear-on-read read or a write-one-to-clear write to the same register, so that the sampled edge and the clear strobe are accepted together. In clear-on-read mode the read must return the old contents and a follow-up read must still show the bit. In write-one mode a read after the write must still show the bit, and only a second write may remove it.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  typedef enum logic [2:0] {
    RG_STAT,
    RG_MASK,
    RG_LIVE,
    RG_CFG,
    RG_NONE
  } region_e;
endpackage

// File: rtl/irq_live_sampler.sv
module irq_live_sampler #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] live_in,
  output logic [W-1:0] live_q,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] live_prev;

  // During reset both stages track the input, so a level that does not
  // move across reset release yields no change pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= live_in;
      live_prev <= live_in;
    end else begin
      live_q    <= live_in;
      live_prev <= live_q;
    end
  end

  assign chg_o = live_q ^ live_prev;
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  // A set has priority over a clear on the same bit.
  always_ff @(posedge clk) begin
    if (rst) stat_o <= '0;
    else     stat_o <= (stat_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wd,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)     mask_o <= '1;
    else if (we) mask_o <= wd;
  end
endmodule

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_stat_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REGS*REG_W-1:0] live_in,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      rd_en,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      irq_out
);
  localparam int TOT_W = NUM_REGS * REG_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] A_LIVE = ADDR_W'(2 * NUM_REGS);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(3 * NUM_REGS);

  logic [TOT_W-1:0]  live_all;
  logic [TOT_W-1:0]  edge_all;
  logic [TOT_W-1:0]  stat_all;
  logic [TOT_W-1:0]  mask_all;
  logic              cor_q;
  region_e           region;
  logic [ADDR_W-1:0] idx;
  logic [REG_W-1:0]  rd_mux;

  irq_live_sampler #(.W(TOT_W)) u_sampler (
    .clk     (clk),
    .rst     (rst),
    .live_in (live_in),
    .live_q  (live_all),
    .chg_o   (edge_all)
  );

  // Address decode into a region and an index within it.
  always_comb begin
    region = RG_NONE;
    idx    = '0;
    if (addr < A_MASK) begin
      region = RG_STAT;
      idx    = addr;
    end else if (addr < A_LIVE) begin
      region = RG_MASK;
      idx    = addr - A_MASK;
    end else if (addr < A_CFG) begin
      region = RG_LIVE;
      idx    = addr - A_LIVE;
    end else if (addr == A_CFG) begin
      region = RG_CFG;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             sel_stat;
    logic             sel_mask;
    logic [REG_W-1:0] clr_vec;

    assign sel_stat = (region == RG_STAT) && (idx == ADDR_W'(g));
    assign sel_mask = (region == RG_MASK) && (idx == ADDR_W'(g));

    always_comb begin
      clr_vec = '0;
      if (cor_q) begin
        if (rd_en && sel_stat) clr_vec = '1;
      end else begin
        if (wr_en && sel_stat) clr_vec = wr_data[REG_W-1:0];
      end
    end

    irq_stat_reg #(.W(REG_W)) u_stat (
      .clk    (clk),
      .rst    (rst),
      .set_i  (edge_all[g*REG_W +: REG_W]),
      .clr_i  (clr_vec),
      .stat_o (stat_all[g*REG_W +: REG_W])
    );

    irq_mask_reg #(.W(REG_W)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && sel_mask),
      .wd     (wr_data[REG_W-1:0]),
      .mask_o (mask_all[g*REG_W +: REG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)                            cor_q <= 1'b1;
    else if (wr_en && region == RG_CFG) cor_q <= wr_data[0];
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == ADDR_W'(k)) begin
        case (region)
          RG_STAT: rd_mux = stat_all[k*REG_W +: REG_W];
          RG_MASK: rd_mux = mask_all[k*REG_W +: REG_W];
          RG_LIVE: rd_mux = live_all[k*REG_W +: REG_W];
          default: ;
        endcase
      end
    end
    if (region == RG_CFG) rd_mux = REG_W'(cor_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_out <= 1'b0;
    end else begin
      if (rd_en) rd_data <= DATA_W'(rd_mux);
      irq_out <= |(stat_all & ~mask_all);
    end
  end
endmodule

// File: rtl/irq_stat_bank_chk.sv
module irq_stat_bank_chk #(
  parameter int NUM_REGS = 3,
  parameter int REG_W    = 16,
  parameter int ADDR_W   = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      rd_en,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         addr,
  input logic                      irq_out,
  input logic                      cor,
  input logic [NUM_REGS*REG_W-1:0] stat_all,
  input logic [NUM_REGS*REG_W-1:0] mask_all,
  input logic [NUM_REGS*REG_W-1:0] edge_all
);
  // R1: a clear-on-read of register 0 leaves only bits set by new edges.
  p_cor_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (cor && rd_en && !wr_en && addr == '0) |=>
      (stat_all[REG_W-1:0] == $past(edge_all[REG_W-1:0])));

  // R2: in write-one mode no status bit drops without a write.
  p_w1c_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!cor && !wr_en) |=> ((stat_all & $past(stat_all)) == $past(stat_all)));

  // R3: values right after reset release.
  p_reset_vals_r3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cor && (&mask_all) && stat_all == '0 && !irq_out));

  // R4, R5, R7: every detected change is latched, even against a clear.
  p_set_edge_r4: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((stat_all & $past(edge_all)) == $past(edge_all)));

  // R6: with every source masked the request stays low.
  p_mask_all_r6: assert property (@(posedge clk) disable iff (rst)
    (&mask_all) |=> !irq_out);
endmodule

bind irq_stat_bank irq_stat_bank_chk #(
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W),
  .ADDR_W   (ADDR_W)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .irq_out  (irq_out),
  .cor      (cor_q),
  .stat_all (stat_all),
  .mask_all (mask_all),
  .edge_all (edge_all)
);

// File: tb/irq_stat_bank_tb_top.sv
`timescale 1ns/1ps
module irq_stat_bank_tb_top;
  localparam int NR = 3;
  localparam int RW = 16;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NR*RW-1:0] live = '0;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_stat_bank #(.NUM_REGS(NR), .REG_W(RW), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .live_in (live),
    .addr    (addr),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_out (irq_out)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr  = a;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d     = rd_data;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr    = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic toggle(input int b);
    @(negedge clk);
    live[b] = ~live[b];
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    live = 48'h00F0_1234_8001;
    rst  = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    chk("R3 rd_data", rd_data, 16'h0000);
    chk("R3 irq", {15'd0, irq_out}, 16'h0000);
    idle(3);
    for (int k = 0; k < NR; k++) begin
      rd(AW'(k), d);
      chk("R8 no status after reset", d, 16'h0000);
      rd(AW'(3 + k), d);
      chk("R3 mask reset", d, 16'hFFFF);
    end
    rd(4'd9, d);
    chk("R3 policy reset", d, 16'h0001);
  endtask

  task automatic t_rise_fall;
    logic [DW-1:0] d;
    live[2] = 1'b0;
    idle(4);
    rd(4'd0, d);
    toggle(2);
    idle(3);
    rd(4'd0, d);
    chk("R4 rising sets bit", d, 16'h0004);
    rd(4'd0, d);
    chk("R1 cleared by read", d, 16'h0000);
    toggle(2);
    idle(3);
    wr(4'd0, 16'hFFFF);
    rd(4'd0, d);
    chk("R5 falling sets bit, R2 write ignored in clear-on-read", d, 16'h0004);
  endtask

  task automatic t_multi;
    logic [DW-1:0] d;
    toggle(16);
    toggle(31);
    idle(3);
    rd(4'd1, d);
    chk("R1 pre-clear value", d, 16'h8001);
    rd(4'd1, d);
    chk("R1 whole register cleared", d, 16'h0000);
  endtask

  task automatic t_live;
    logic [DW-1:0] d;
    toggle(7);
    idle(3);
    rd(4'd6, d);
    chk("R9 live readback", d, live[15:0]);
    rd(4'd0, d);
    chk("R9 live read does not clear", d, 16'h0080);
    rd(4'd0, d);
    chk("R1 clear after live check", d, 16'h0000);
  endtask

  task automatic t_mask;
    logic [DW-1:0] d;
    toggle(36);
    idle(4);
    chk("R6 masked no irq", {15'd0, irq_out}, 16'h0000);
    wr(4'd5, 16'hFFEF);
    rd(4'd5, d);
    chk("R10 mask readback", d, 16'hFFEF);
    idle(1);
    chk("R6 unmasked irq", {15'd0, irq_out}, 16'h0001);
    rd(4'd2, d);
    chk("R1 reg2 pre-clear", d, 16'h0010);
    idle(2);
    chk("R6 irq drops after clear", {15'd0, irq_out}, 16'h0000);
    wr(4'd5, 16'hFFFF);
    rd(4'd12, d);
    chk("R10 unmapped reads zero", d, 16'h0000);
  endtask

  task automatic t_w1c;
    logic [DW-1:0] d;
    wr(4'd9, 16'h0000);
    rd(4'd9, d);
    chk("R10 policy readback", d, 16'h0000);
    toggle(1);
    toggle(3);
    idle(3);
    rd(4'd0, d);
    chk("R2 bits set", d, 16'h000A);
    rd(4'd0, d);
    chk("R2 read does not clear", d, 16'h000A);
    wr(4'd0, 16'h0002);
    rd(4'd0, d);
    chk("R2 write one clears only that bit", d, 16'h0008);
    wr(4'd0, 16'h0000);
    rd(4'd0, d);
    chk("R2 write zero keeps", d, 16'h0008);
  endtask

  task automatic t_setwins;
    logic [DW-1:0] d;
    toggle(3);
    wr(4'd0, 16'h0008);
    rd(4'd0, d);
    chk("R7 set wins over write-one clear", d, 16'h0008);
    wr(4'd0, 16'h0008);
    rd(4'd0, d);
    chk("R2 second clear", d, 16'h0000);
    wr(4'd9, 16'h0001);
    toggle(25);
    idle(3);
    toggle(25);
    rd(4'd1, d);
    chk("R7 read returns old value", d, 16'h0200);
    rd(4'd1, d);
    chk("R7 set wins over clear-on-read", d, 16'h0200);
    rd(4'd1, d);
    chk("R1 final clear", d, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_rise_fall();
    t_multi();
    t_live();
    t_mask();
    t_w1c();
    t_setwins();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule